// File: doc/BRIEF.md
# Loop-Aware Exception Return Adjuster

This block works out where a trap handler should resume when it returns to code that may sit inside one of two nested hardware loops. The handler hands over the saved trap PC, the 32-bit instruction word found at that PC, and the start, end and iteration count of each loop level. The block answers with the resume address and with a decrement strobe for the loop counter it consumed, if any. The handler then writes the address back and decrements that counter.

The choice follows a fixed priority list, and the first check that matches wins. A trap on the last instruction of a loop either wraps back to the loop start or exits the loop. Level 0, the inner loop, is checked before level 1. A trap elsewhere in a loop body steps over the trapping instruction. Outside any loop, an environment call or a full-size breakpoint is stepped over by 4 bytes and a compressed breakpoint by 2 bytes. In every other case the saved PC is returned unchanged.

The block takes one request per cycle when `req_valid` is high. The result is registered and appears with `rsp_valid` on the following cycle.

Top module: `loop_trap_resume`

## Requirements
- R1: After reset `rsp_valid`, `ret_pc` and `dec` are all zero. `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high.
- R2: If `epc` equals `lp_end[0]-4` and `lp_count[0]` is greater than 1, `ret_pc` is `lp_start[0]` and `dec` is 2'b01.
- R3: If `epc` equals `lp_end[0]-4` and `lp_count[0]` equals 1, `ret_pc` is `epc+4` and `dec` is 2'b01.
- R4: The two rules of R2 and R3 apply to level 1 in the same way, with `dec` equal to 2'b10. They are considered only when neither level-0 rule matches.
- R5: If no end rule matches and `epc` lies in `[lp_start[i], lp_end[i]-4)` for either level, `ret_pc` is `epc+4` and `dec` is 0. This holds whatever the instruction word is.
- R6: Otherwise, if `insn` equals 32'h00000073 (environment call) or 32'h00100073 (breakpoint), `ret_pc` is `epc+4`, computed modulo 2^32, and `dec` is 0.
- R7: Otherwise, if `insn[15:0]` equals 16'h9002 (compressed breakpoint), `ret_pc` is `epc+2` and `dec` is 0. `insn[31:16]` is ignored.
- R8: If no rule matches, `ret_pc` equals `epc` and `dec` is 0.
- R9: At most one bit of `dec` is set, and only while `rsp_valid` is high.
- R10: A level whose count is 0 never matches an end rule, even when `epc` equals its end minus 4. Evaluation then continues with the later rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Evaluate the inputs this cycle |
| epc | input | 32 | Saved trap PC |
| insn | input | 32 | Instruction word stored at `epc` |
| lp_start | input | 2x32 | Loop start address per level |
| lp_end | input | 2x32 | Loop end address per level (one past the last instruction) |
| lp_count | input | 2x32 | Remaining iterations per level |
| rsp_valid | output | 1 | Result valid |
| ret_pc | output | 32 | Adjusted resume PC |
| dec | output | 2 | Counter decrement strobe per level |

## Verification
The assertions check on every cycle the one-cycle request-to-response timing, the single-strobe limit and its qualification by `rsp_valid`. They also check the level-0 wrap target against the start address sampled one cycle earlier. Only the bench scenarios can show the full ordering of the list. This covers level 0 beating level 1 on a shared end address, a loop body beating an environment call, zero-count levels falling through, and the compressed breakpoint ignoring its upper halfword. The bench also covers address wrap at the top of memory and the exact resume addresses of every rule.

// File: rtl/lpr_pkg.sv
// Package: shared encodings and rule kinds for the loop-aware resume adjuster.
// Assumes 32-bit instruction words. The compressed breakpoint is compared on the low halfword only.
package lpr_pkg;
    localparam logic [31:0] INSN_ECALL   = 32'h0000_0073;
    localparam logic [31:0] INSN_EBREAK  = 32'h0010_0073;
    localparam logic [15:0] INSN_CEBREAK = 16'h9002;

    // Which rule of the priority list was selected
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_WRAP  = 3'd1,
        K_EXIT  = 3'd2,
        K_BODY  = 3'd3,
        K_STEP4 = 3'd4,
        K_STEP2 = 3'd5
    } rule_kind_e;
endpackage

// File: rtl/lpr_level_probe.sv
// Module: evaluates the saved PC against one loop level.
// Reports the last-instruction hit (split into wrap and exit by count) and body membership.
// Assumes end >= start + 4. Address arithmetic wraps modulo 2^ADDR_W.
module lpr_level_probe #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] lp_start,
    input  logic [ADDR_W-1:0] lp_end,
    input  logic [CNT_W-1:0]  lp_count,
    output logic              wrap,
    output logic              leave,
    output logic              in_body
);
    logic [ADDR_W-1:0] last_pc;
    logic              at_last;

    // Compare the PC with the last body instruction and with the body range
    always_comb begin
        last_pc = lp_end - ADDR_W'(4);
        at_last = (pc == last_pc);
        wrap    = at_last && (lp_count > CNT_W'(1));
        leave   = at_last && (lp_count == CNT_W'(1));
        in_body = (pc >= lp_start) && (pc < last_pc);
    end
endmodule

// File: rtl/lpr_insn_class.sv
// Module: classifies the trapping instruction word into full-size traps and the compressed breakpoint.
// Assumes the word is the one stored at the saved PC.
module lpr_insn_class
    import lpr_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output logic              full_trap,
    output logic              half_brk
);
    // Decode the exact encodings
    always_comb begin
        full_trap = (insn == INSN_W'(INSN_ECALL)) || (insn == INSN_W'(INSN_EBREAK));
        half_brk  = (insn[15:0] == INSN_CEBREAK);
    end
endmodule

// File: rtl/lpr_rule_pick.sv
// Module: applies the fixed priority list and returns the first matching rule and its level.
// Assumes at least two levels. Lower level indices take precedence for the end rules.
module lpr_rule_pick
    import lpr_pkg::*;
#(
    parameter int LEVELS = 2,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] wrap,
    input  logic [LEVELS-1:0] leave,
    input  logic [LEVELS-1:0] in_body,
    input  logic              full_trap,
    input  logic              half_brk,
    output rule_kind_e        kind,
    output logic [LVL_W-1:0]  lvl
);
    logic found;

    // Walk the levels in order (wrap before exit), then the non-loop rules
    always_comb begin
        kind  = K_NONE;
        lvl   = '0;
        found = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (!found && wrap[i]) begin
                kind  = K_WRAP;
                lvl   = LVL_W'(i);
                found = 1'b1;
            end else if (!found && leave[i]) begin
                kind  = K_EXIT;
                lvl   = LVL_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            if (|in_body)       kind = K_BODY;
            else if (full_trap) kind = K_STEP4;
            else if (half_brk)  kind = K_STEP2;
        end
    end
endmodule

// File: rtl/loop_trap_resume.sv
// Module: top of the loop-aware trap resume adjuster.
// Computes the resume PC and a counter decrement strobe from the saved PC, the instruction word and the loop registers.
// Registers the result one cycle after req_valid. Strobes are only set alongside rsp_valid.
module loop_trap_resume
    import lpr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int INSN_W = 32,
    parameter int LEVELS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:0]              epc,
    input  logic [INSN_W-1:0]              insn,
    input  logic [LEVELS-1:0][ADDR_W-1:0]  lp_start,
    input  logic [LEVELS-1:0][ADDR_W-1:0]  lp_end,
    input  logic [LEVELS-1:0][CNT_W-1:0]   lp_count,
    output logic                           rsp_valid,
    output logic [ADDR_W-1:0]              ret_pc,
    output logic [LEVELS-1:0]              dec
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [LEVELS-1:0] wrap_v, leave_v, body_v;
    logic              full_trap, half_brk;
    rule_kind_e        kind;
    logic [LVL_W-1:0]  lvl;
    logic [ADDR_W-1:0] next_pc;
    logic [LEVELS-1:0] next_dec;

    // One probe per loop level
    for (genvar g = 0; g < LEVELS; g++) begin : g_probe
        lpr_level_probe #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_probe (
            .pc       (epc),
            .lp_start (lp_start[g]),
            .lp_end   (lp_end[g]),
            .lp_count (lp_count[g]),
            .wrap     (wrap_v[g]),
            .leave    (leave_v[g]),
            .in_body  (body_v[g])
        );
    end

    lpr_insn_class #(.INSN_W(INSN_W)) i_class (
        .insn      (insn),
        .full_trap (full_trap),
        .half_brk  (half_brk)
    );

    lpr_rule_pick #(.LEVELS(LEVELS), .LVL_W(LVL_W)) i_pick (
        .wrap      (wrap_v),
        .leave     (leave_v),
        .in_body   (body_v),
        .full_trap (full_trap),
        .half_brk  (half_brk),
        .kind      (kind),
        .lvl       (lvl)
    );

    // Turn the selected rule into a resume address and a strobe
    always_comb begin
        next_pc  = epc;
        next_dec = '0;
        unique case (kind)
            K_WRAP: begin
                next_pc  = lp_start[lvl];
                next_dec = LEVELS'(1) << lvl;
            end
            K_EXIT: begin
                next_pc  = epc + ADDR_W'(4);
                next_dec = LEVELS'(1) << lvl;
            end
            K_BODY, K_STEP4: next_pc = epc + ADDR_W'(4);
            K_STEP2:         next_pc = epc + ADDR_W'(2);
            default:         next_pc = epc;
        endcase
    end

    // Response register: capture on request, clear strobes when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            ret_pc    <= '0;
            dec       <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                ret_pc <= next_pc;
                dec    <= next_dec;
            end else begin
                dec    <= '0;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R1
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec) <= 1);  // R9
    AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec) |-> rsp_valid);  // R9
    AST_L0_WRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (epc == lp_end[0] - ADDR_W'(4)) && (lp_count[0] > CNT_W'(1)))
        |=> (dec[0] && (ret_pc == $past(lp_start[0]))));  // R2
endmodule

// File: tb/test_loop_trap_resume.sv
module test_loop_trap_resume;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       epc = '0;
    logic [31:0]       insn = '0;
    logic [1:0][31:0]  lp_start = '0;
    logic [1:0][31:0]  lp_end = '0;
    logic [1:0][31:0]  lp_count = '0;
    logic              rsp_valid;
    logic [31:0]       ret_pc;
    logic [1:0]        dec;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    loop_trap_resume i_loop_trap_resume (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .epc(epc), .insn(insn),
        .lp_start(lp_start), .lp_end(lp_end), .lp_count(lp_count),
        .rsp_valid(rsp_valid), .ret_pc(ret_pc), .dec(dec)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_loops(logic [31:0] s0, logic [31:0] e0, logic [31:0] c0,
                             logic [31:0] s1, logic [31:0] e1, logic [31:0] c1);
        lp_start[0] = s0; lp_end[0] = e0; lp_count[0] = c0;
        lp_start[1] = s1; lp_end[1] = e1; lp_count[1] = c1;
    endtask

    // One request, result sampled on the next falling edge
    task automatic eval(string req, logic [31:0] pc, logic [31:0] word,
                        logic [31:0] exp_pc, logic [1:0] exp_dec);
        @(negedge clk);
        epc = pc; insn = word; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "ret_pc", ret_pc, exp_pc);
        check(req, "dec", 32'(dec), 32'(exp_dec));
        check("R9", "strobe count", 32'($countones(dec)), 32'($countones(exp_dec)));
    endtask

    task automatic t_reset;
        check("R1", "reset rsp_valid", 32'(rsp_valid), 0);
        check("R1", "reset ret_pc", ret_pc, 0);
        check("R1", "reset dec", 32'(dec), 0);
    endtask

    task automatic t_loop0_end;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R2", 32'h10C, 32'h13, 32'h100, 2'b01);
        lp_count[0] = 1;
        eval("R3", 32'h10C, 32'h13, 32'h110, 2'b01);
    endtask

    task automatic t_loop1_end;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R4", 32'h21C, 32'h13, 32'h200, 2'b10);
        lp_count[1] = 1;
        eval("R4", 32'h21C, 32'h13, 32'h220, 2'b10);
        // shared end address: level 0 wins
        set_loops(32'h110, 32'h120, 2, 32'h100, 32'h120, 2);
        eval("R4", 32'h11C, 32'h13, 32'h110, 2'b01);
    endtask

    task automatic t_body;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R5", 32'h104, 32'h73, 32'h108, 2'b00);
        eval("R5", 32'h208, 32'h9002, 32'h20C, 2'b00);
    endtask

    task automatic t_trap;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R6", 32'h400, 32'h0000_0073, 32'h404, 2'b00);
        eval("R6", 32'h400, 32'h0010_0073, 32'h404, 2'b00);
        eval("R6", 32'hFFFF_FFFC, 32'h0000_0073, 32'h0, 2'b00);
    endtask

    task automatic t_cbrk;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R7", 32'h400, 32'h0000_9002, 32'h402, 2'b00);
        eval("R7", 32'h400, 32'hABCD_9002, 32'h402, 2'b00);
    endtask

    task automatic t_nomatch;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        eval("R8", 32'h400, 32'h0000_0013, 32'h400, 2'b00);
        eval("R8", 32'h110, 32'h0020_0073, 32'h110, 2'b00);
    endtask

    task automatic t_zero_count;
        set_loops(32'h100, 32'h110, 0, 32'h200, 32'h220, 0);
        eval("R10", 32'h10C, 32'h13, 32'h10C, 2'b00);
        eval("R10", 32'h21C, 32'h0000_0073, 32'h220, 2'b00);
    endtask

    task automatic t_handshake;
        set_loops(32'h100, 32'h110, 5, 32'h200, 32'h220, 3);
        @(negedge clk);
        epc = 32'h10C; insn = 32'h13; req_valid = 1'b1;
        @(negedge clk);
        check("R1", "first of pair valid", 32'(rsp_valid), 1);
        check("R1", "first of pair pc", ret_pc, 32'h100);
        epc = 32'h400; insn = 32'h0000_9002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "second of pair valid", 32'(rsp_valid), 1);
        check("R1", "second of pair pc", ret_pc, 32'h402);
        check("R9", "second of pair dec", 32'(dec), 0);
        @(negedge clk);
        check("R1", "idle valid", 32'(rsp_valid), 0);
        check("R9", "idle dec", 32'(dec), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_loop0_end();
        t_loop1_end();
        t_body();
        t_trap();
        t_cbrk();
        t_nomatch();
        t_zero_count();
        t_handshake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule